// File: doc/BRIEF.md
# Dual Parallel Port Group with Control Word

This block gives a host a byte-wide register window onto a bank of general-purpose pins. The pins are split into identical groups, each holding three 8-bit ports (A, B and C) and one control register. A write to a port offset loads that port's output latch. A read of a port offset returns what is on the pins: the outside value for bits configured as inputs and the latch value for bits configured as outputs.

The control register takes two kinds of write, chosen by bit 7. With bit 7 set, the write is a mode-set command. It sets the direction of port A, of port B and of each nibble of port C, and it clears all three output latches of the group. With bit 7 clear, the write sets or clears one port C latch bit and leaves the directions alone. Each pin has an output enable, taken straight from the direction state, so a pin drives only while it is configured as an output. The bus is synchronous: a write takes effect on the clock edge that samples it, and read data is registered on the edge that samples the read strobe.

Top module: `pio_dual_group`

## Requirements
- R1: After reset every port of every group is an input (all `pin_oe` bits 0), every output latch is 0, `pin_out` is 0, `bus_rdata` is 0, and a read of a control offset returns 0x9B.
- R2: Group g occupies bus offsets 4g (port A), 4g+1 (port B), 4g+2 (port C) and 4g+3 (control). Port P of group g (A=0, B=1, C=2) maps to pin bits 24g+8P up to 24g+8P+7.
- R3: A write to a port offset loads the whole 8-bit latch of that port. From the next cycle, each output bit of that port shows the written bit on `pin_out` with `pin_oe` set to 1.
- R4: A control write with bit 7 = 1 sets the directions, where 1 means input: bit 4 sets port A, bit 1 sets port B, bit 0 sets port C bits 3:0 and bit 3 sets port C bits 7:4. Bits 6, 5 and 2 have no effect.
- R5: A control write with bit 7 = 1 clears all three output latches of the addressed group. The other group's latches and directions are unchanged.
- R6: A control write with bit 7 = 0 writes the value of bit 0 into port C latch bit number bits 3:1. All directions and the latches of ports A and B are unchanged.
- R7: `pin_oe` for a bit is the inverse of its direction, and `pin_out` is 0 for every bit whose `pin_oe` is 0.
- R8: A read strobe on a port offset loads `bus_rdata` on that clock edge. Each bit is the `pin_in` value if that bit is an input and the latch value if it is an output. `bus_rdata` holds its value in every cycle without a read strobe.
- R9: A read of a control offset returns {1, 0, 0, A, Chigh, 0, B, Clow}, with the direction flags at bit positions 4, 3, 1 and 0 (1 = input).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register offset: group index above a 2-bit register select |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | PIN_W (48) | Outside pin levels, 24 bits per group |
| pin_out | output | PIN_W (48) | Driven pin levels, 0 where not enabled |
| pin_oe | output | PIN_W (48) | Per-pin output enable |

## Verification
The bench sweeps all sixteen direction codes in both groups. It sets bits 6, 5 and 2 of the mode-set word to patterns that vary with the code. A decoder that read the wrong bit, or that tied the two halves of port C together, would give the wrong enables in some of the sixteen codes. After every mode-set it compares all 48 enables and outputs. A design that kept old latch values, or that cleared or reconfigured the group that was not addressed, would show nonzero or changed bits there. Read-back under mixed directions catches a read that returns the latch for input bits or the pins for output bits. A sweep of all sixteen bit-set/reset codes catches a wrong bit index, a polarity swap, or a direction change on a command with bit 7 clear.

// File: rtl/pio_pkg.sv
package pio_pkg;
   // Control word bit positions; these positions define the command format.
   localparam int CW_MODE_BIT = 7;
   localparam int CW_A_BIT    = 4;
   localparam int CW_CHI_BIT  = 3;
   localparam int CW_B_BIT    = 1;
   localparam int CW_CLO_BIT  = 0;

   typedef enum logic [1:0] {
      SEL_PA   = 2'd0,
      SEL_PB   = 2'd1,
      SEL_PC   = 2'd2,
      SEL_CTRL = 2'd3
   } pio_sel_e;

   // Direction flags of one group, 1 = input.
   typedef struct packed {
      logic a_in;
      logic chi_in;
      logic b_in;
      logic clo_in;
   } pio_dir_t;

   localparam pio_dir_t DIR_RESET = '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};
endpackage

// File: rtl/pio_port_reg.sv
module pio_port_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         clr,
   input  logic [W-1:0] dir_in,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] latch_q,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latch_q <= '0;
      else if (clr)   latch_q <= '0;
      else if (load)  latch_q <= load_val;
   end

   assign pin_oe  = ~dir_in;
   assign pin_out = latch_q & pin_oe;
   assign rd_val  = (pin_in & dir_in) | (latch_q & ~dir_in);
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
   import pio_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [7:0]       wdata,
   output pio_dir_t         dir,
   output logic             mode_set,
   output logic             bit_cmd,
   output logic [IDX_W-1:0] bit_idx,
   output logic             bit_val,
   output logic [7:0]       ctrl_img
);
   logic [1:0] unused_cw;

   assign mode_set = ctrl_wr &  wdata[CW_MODE_BIT];
   assign bit_cmd  = ctrl_wr & ~wdata[CW_MODE_BIT];
   assign bit_idx  = wdata[IDX_W:1];
   assign bit_val  = wdata[0];
   assign unused_cw = wdata[6:5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir <= DIR_RESET;
      else if (mode_set) begin
         dir.a_in   <= wdata[CW_A_BIT];
         dir.chi_in <= wdata[CW_CHI_BIT];
         dir.b_in   <= wdata[CW_B_BIT];
         dir.clo_in <= wdata[CW_CLO_BIT];
      end
   end

   always_comb begin
      ctrl_img              = 8'h00;
      ctrl_img[CW_MODE_BIT] = 1'b1;
      ctrl_img[CW_A_BIT]    = dir.a_in;
      ctrl_img[CW_CHI_BIT]  = dir.chi_in;
      ctrl_img[CW_B_BIT]    = dir.b_in;
      ctrl_img[CW_CLO_BIT]  = dir.clo_in;
   end
endmodule

// File: rtl/pio_group.sv
module pio_group
   import pio_pkg::*;
#(
   parameter int PORT_W = 8,
   localparam int NPORT = 3,
   localparam int IDX_W = $clog2(PORT_W),
   localparam int HALF  = PORT_W / 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            reg_sel,
   input  logic [7:0]            wdata,
   input  logic [NPORT*PORT_W-1:0] pin_in,
   output logic [NPORT*PORT_W-1:0] pin_out,
   output logic [NPORT*PORT_W-1:0] pin_oe,
   output logic [7:0]            rd_byte
);
   pio_dir_t         dir;
   logic             mode_set, bit_cmd, bit_val;
   logic [IDX_W-1:0] bit_idx;
   logic [7:0]       ctrl_img;
   logic [PORT_W-1:0] lat_q  [NPORT];
   logic [PORT_W-1:0] rd_val [NPORT];
   logic [PORT_W-1:0] dir_v  [NPORT];
   logic [PORT_W-1:0] unused_ab;

   pio_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (wr_en && reg_sel == SEL_CTRL),
      .wdata    (wdata),
      .dir      (dir),
      .mode_set (mode_set),
      .bit_cmd  (bit_cmd),
      .bit_idx  (bit_idx),
      .bit_val  (bit_val),
      .ctrl_img (ctrl_img)
   );

   assign dir_v[0] = {PORT_W{dir.a_in}};
   assign dir_v[1] = {PORT_W{dir.b_in}};
   assign dir_v[2] = {{(PORT_W-HALF){dir.chi_in}}, {HALF{dir.clo_in}}};
   assign unused_ab = lat_q[0] ^ lat_q[1];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic              ld;
      logic [PORT_W-1:0] ld_val;
      if (p == int'(SEL_PC)) begin : g_bitcmd
         logic [PORT_W-1:0] patched;
         always_comb begin
            patched          = lat_q[p];
            patched[bit_idx] = bit_val;
         end
         assign ld     = (wr_en && reg_sel == 2'(p)) || bit_cmd;
         assign ld_val = bit_cmd ? patched : wdata[PORT_W-1:0];
      end else begin : g_plain
         assign ld     = wr_en && reg_sel == 2'(p);
         assign ld_val = wdata[PORT_W-1:0];
      end

      pio_port_reg #(.W(PORT_W)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ld),
         .load_val (ld_val),
         .clr      (mode_set),
         .dir_in   (dir_v[p]),
         .pin_in   (pin_in[p*PORT_W +: PORT_W]),
         .latch_q  (lat_q[p]),
         .pin_out  (pin_out[p*PORT_W +: PORT_W]),
         .pin_oe   (pin_oe[p*PORT_W +: PORT_W]),
         .rd_val   (rd_val[p])
      );
   end

   always_comb begin
      unique case (reg_sel)
         SEL_PA:  rd_byte = rd_val[0];
         SEL_PB:  rd_byte = rd_val[1];
         SEL_PC:  rd_byte = rd_val[2];
         default: rd_byte = ctrl_img;
      endcase
   end
endmodule

// File: rtl/pio_dual_group.sv
module pio_dual_group #(
   parameter int NUM_GROUPS = 2,
   parameter int PORT_W     = 8,
   localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int GRP_SLOTS = 1 << GRP_W,
   localparam int ADDR_W    = GRP_W + 2,
   localparam int GRP_PINS  = 3 * PORT_W,
   localparam int PIN_W     = NUM_GROUPS * GRP_PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);
   if (PORT_W != 8) begin : g_bad_width
      $error("pio_dual_group: control word format needs PORT_W == 8");
   end
   if (NUM_GROUPS < 1 || NUM_GROUPS > 16) begin : g_bad_groups
      $error("pio_dual_group: NUM_GROUPS must be 1..16");
   end

   logic [GRP_W-1:0] grp_sel;
   logic [1:0]       reg_sel;
   logic [7:0]       grp_rd [GRP_SLOTS];

   assign grp_sel = bus_addr[ADDR_W-1:2];
   assign reg_sel = bus_addr[1:0];

   for (genvar g = 0; g < GRP_SLOTS; g++) begin : g_grp
      if (g < NUM_GROUPS) begin : g_live
         pio_group #(.PORT_W(PORT_W)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && grp_sel == GRP_W'(g)),
            .reg_sel (reg_sel),
            .wdata   (bus_wdata),
            .pin_in  (pin_in[g*GRP_PINS +: GRP_PINS]),
            .pin_out (pin_out[g*GRP_PINS +: GRP_PINS]),
            .pin_oe  (pin_oe[g*GRP_PINS +: GRP_PINS]),
            .rd_byte (grp_rd[g])
         );
      end else begin : g_hole
         assign grp_rd[g] = 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= 8'h00;
      else if (bus_rd) bus_rdata <= grp_rd[grp_sel];
   end
endmodule

// File: rtl/pio_dual_group_chk.sv
module pio_dual_group_chk #(
   parameter int NUM_GROUPS = 2,
   parameter int PORT_W     = 8,
   localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int ADDR_W    = GRP_W + 2,
   localparam int PIN_W     = NUM_GROUPS * 3 * PORT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe
);
   localparam logic [ADDR_W-1:0] CTRL0 = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] PA0   = ADDR_W'(0);

   // R4: port A enables of group 0 follow the mode-set word
   a_r4_modeset_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL0 && bus_wdata[7])
      |=> pin_oe[PORT_W-1:0] == {PORT_W{~$past(bus_wdata[4])}});

   // R5: mode-set leaves group 0 driving nothing but zeros
   a_r5_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL0 && bus_wdata[7])
      |=> pin_out[3*PORT_W-1:0] == '0);

   // R6: bit set/reset commands never move an enable
   a_r6_bitcmd_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL0 && !bus_wdata[7])
      |=> $stable(pin_oe));

   // R3: written port A value appears on enabled pins
   a_r3_port_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == PA0)
      |=> pin_out[PORT_W-1:0] == ($past(bus_wdata[PORT_W-1:0]) & pin_oe[PORT_W-1:0]));

   // R8: read data holds without a read strobe
   a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R9: control read-back carries the flag in bit 7
   a_r9_ctrl_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == CTRL0) |=> bus_rdata[7]);
endmodule

bind pio_dual_group pio_dual_group_chk #(.NUM_GROUPS(NUM_GROUPS), .PORT_W(PORT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/tb_pio_dual_group.sv
`timescale 1ns/1ps
module tb_pio_dual_group;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in = '0;
   logic [47:0] pin_out, pin_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // model: dir bits [3]=A [2]=C high [1]=B [0]=C low, 1 = input
   logic [3:0] m_dir [2];
   logic [7:0] m_lat [2][3];

   always #2.5 clk = ~clk;

   pio_dual_group dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [7:0] oe_of(int g, int p);
      case (p)
         0:       return {8{~m_dir[g][3]}};
         1:       return {8{~m_dir[g][1]}};
         default: return {{4{~m_dir[g][2]}}, {4{~m_dir[g][0]}}};
      endcase
   endfunction

   function automatic logic [47:0] exp_oe();
      logic [47:0] v;
      for (int g = 0; g < 2; g++)
         for (int p = 0; p < 3; p++) v[g*24 + p*8 +: 8] = oe_of(g, p);
      return v;
   endfunction

   function automatic logic [47:0] exp_out();
      logic [47:0] v;
      for (int g = 0; g < 2; g++)
         for (int p = 0; p < 3; p++) v[g*24 + p*8 +: 8] = m_lat[g][p] & oe_of(g, p);
      return v;
   endfunction

   task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [2:0] a, output logic [7:0] r);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      r = bus_rdata;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [7:0] r, held;
      for (int g = 0; g < 2; g++) begin
         m_dir[g] = 4'hF;
         for (int p = 0; p < 3; p++) m_lat[g][p] = 8'h00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset oe", pin_oe, 48'h0);
      chk("R1 reset out", pin_out, 48'h0);
      chk("R1 reset rdata", {40'h0, bus_rdata}, 48'h0);
      bus_read(3'd7, r);
      chk("R1 R9 reset ctrl", {40'h0, r}, 48'h9B);

      // direction sweep over all codes in both groups
      for (int g = 0; g < 2; g++) begin
         for (int m = 0; m < 16; m++) begin
            logic [3:0] c;
            logic [7:0] w;
            c = 4'(m);
            // bits 6,5,2 carry noise that must be ignored
            w = {1'b1, c[0], c[0], c[3], c[2], c[1], c[1], c[0]};
            bus_write({g[0], 2'b11}, w);
            m_dir[g] = c;
            for (int p = 0; p < 3; p++) m_lat[g][p] = 8'h00;
            chk("R4 mode-set enables", pin_oe, exp_oe());
            chk("R5 mode-set clears", pin_out, exp_out());
            bus_read({g[0], 2'b11}, r);
            chk("R9 ctrl readback", {40'h0, r}, {40'h0, 3'b100, c[3], c[2], 1'b0, c[1], c[0]});
            for (int p = 0; p < 3; p++) begin
               logic [7:0] v;
               v = 8'(8'hA5 ^ (m * 29 + p * 71 + g * 5));
               bus_write({g[0], 2'(p)}, v);
               m_lat[g][p] = v;
               chk("R3 R7 port write", pin_out, exp_out());
               chk("R2 R3 enables kept", pin_oe, exp_oe());
            end
            pin_in = {24'(m * 7919 + g * 13), 24'(~(m * 104729))};
            for (int p = 0; p < 3; p++) begin
               logic [7:0] e, o;
               o = oe_of(g, p);
               e = (pin_in[g*24 + p*8 +: 8] & ~o) | (m_lat[g][p] & o);
               bus_read({g[0], 2'(p)}, r);
               chk("R8 R2 port read", {40'h0, r}, {40'h0, e});
            end
         end
      end

      // bit set/reset sweep on port C, all outputs
      for (int g = 0; g < 2; g++) begin
         bus_write({g[0], 2'b11}, 8'h80);
         m_dir[g] = 4'h0;
         for (int p = 0; p < 3; p++) m_lat[g][p] = 8'h00;
         bus_write({g[0], 2'b00}, 8'h3C);
         m_lat[g][0] = 8'h3C;
         for (int i = 0; i < 16; i++) begin
            logic [3:0] ii;
            logic [3:0] code;
            ii = 4'(i);
            code = {ii[2:0], ~ii[3]};
            bus_write({g[0], 2'b11}, {4'h0, code});
            m_lat[g][2][code[3:1]] = code[0];
            chk("R6 bit cmd pins", pin_out, exp_out());
            chk("R6 bit cmd enables", pin_oe, exp_oe());
         end
         bus_read({g[0], 2'b10}, r);
         chk("R6 port C readback", {40'h0, r}, {40'h0, m_lat[g][2]});
      end

      // read data hold
      bus_write(3'b011, 8'h9B);
      m_dir[0] = 4'hF;
      pin_in = 48'h0000_0000_005A;
      bus_read(3'b000, held);
      chk("R8 input read", {40'h0, held}, 48'h5A);
      @(negedge clk);
      pin_in = 48'hFFFF_FFFF_FFA3;
      repeat (3) @(negedge clk);
      chk("R8 rdata holds", {40'h0, bus_rdata}, {40'h0, held});

      summary();
   end
endmodule